// File: doc/BRIEF.md
# UART Receive/Transmit Ready and Interrupt Signalling

This block holds the receive and transmit byte storage of one UART channel and drives three status lines from it: an active-low receive-ready line and an active-low transmit-ready line for a DMA controller, and an active-high interrupt line. The storage works in one of three modes. The mode comes from a FIFO-enable bit and a DMA-mode bit. With FIFOs off, each direction holds a single byte. With FIFOs on, each direction is a 16-entry first-in first-out queue. DMA mode adds hysteresis to receive-ready and changes the transmit-ready rule to a "room left" test.

A mode tracker decodes the three operating modes: `MODE_HOLD`, `MODE_FIFO` and `MODE_DMA`. It also watches the FIFO-enable bit for a change, which produces a one-cycle flush. A two-state receive machine drives receive-ready in DMA mode. It moves `RX_OPEN -> RX_LATCHED` when the receive count is non-zero and either reaches the trigger level or a timeout pulse arrives. It moves `RX_LATCHED -> RX_OPEN` only when the count drops to zero. Leaving DMA mode, or a flush, forces `RX_OPEN`. The interrupt line is the OR of a transmit condition and a receive condition, each gated by its own enable input.

Top module: `uart_rdy_irq`

## Requirements
- R1: While reset is asserted, rxrdy_n and txrdy_n are 1, irq is 0, and both counts are 0.
- R2: With fifo_en=0, the receive side holds at most one byte. A push while one byte is held is ignored. rxrdy_n is 0 while a byte is held and 1 when none is held.
- R3: With fifo_en=0, txrdy_n is 0 when the transmit holding byte is empty and 1 when it holds a byte.
- R4: With fifo_en=1 and dma_mode=0, rxrdy_n is 0 whenever rx_count is 1 or more, and 1 when rx_count is 0.
- R5: With fifo_en=1 and dma_mode=1, rxrdy_n goes to 0 when rx_count is non-zero and either rx_count >= rx_trig or rx_timeout is 1. It then stays 0 until rx_count is 0. A timeout with rx_count=0 has no effect.
- R6: With fifo_en=1 and dma_mode=0, txrdy_n is 0 only when tx_count is 0, and 1 when tx_count is 1 or more.
- R7: With fifo_en=1 and dma_mode=1, txrdy_n is 0 while tx_count < 16 and 1 when tx_count is 16.
- R8: With fifo_en=1, each FIFO holds 16 bytes and returns them in push order on *_dout (the head is shown before the pop). A push when full and a pop when empty are ignored.
- R9: The transmit interrupt condition is true when the transmit side holds no byte, in either FIFO setting.
- R10: The receive interrupt condition is true with fifo_en=0 when a byte is held. With fifo_en=1 it is true when rx_count is non-zero and rx_count >= rx_trig.
- R11: irq = (irq_tx_en AND transmit condition) OR (irq_rx_en AND receive condition). With both enables at 0, irq is 0.
- R12: Any change of fifo_en empties both sides and returns the DMA receive machine to RX_OPEN, so rxrdy_n reads 1.
- R13: rxrdy_n, txrdy_n and irq are registered. They change at the clock edge after the edge that changed a count or control input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects 16-entry FIFOs, 0 selects single-byte holding |
| dma_mode | input | 1 | 1 selects DMA signalling (only with fifo_en=1) |
| rx_trig | input | 5 | Receive trigger level, in bytes |
| rx_timeout | input | 1 | One-cycle receive character-timeout pulse |
| irq_tx_en | input | 1 | Transmit interrupt enable |
| irq_rx_en | input | 1 | Receive interrupt enable |
| rx_push | input | 1 | Write a received byte |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Remove the receive head |
| rx_dout | output | 8 | Receive head byte |
| tx_push | input | 1 | Write a byte to send |
| tx_din | input | 8 | Byte to send |
| tx_pop | input | 1 | Remove the transmit head |
| tx_dout | output | 8 | Transmit head byte |
| rx_count | output | 5 | Bytes held on the receive side |
| tx_count | output | 5 | Bytes held on the transmit side |
| rxrdy_n | output | 1 | Active-low receive-ready |
| txrdy_n | output | 1 | Active-low transmit-ready |
| irq | output | 1 | Interrupt |

## Verification
The hardest situation to reach is the hysteresis of `RX_LATCHED`. The stimulus fills the receive queue up to the trigger level, then drains it one byte at a time. rxrdy_n must stay low until the last byte leaves, even though the count has fallen below the trigger.

The timeout path is driven separately. A single byte is pushed, which is below the trigger, and a timeout pulse is then applied. A second timeout pulse is applied on an empty queue to show it is ignored.

The flush is tested from the worst starting point: a latched machine and a nearly full transmit queue, followed by a change of fifo_en.

// File: rtl/uart_rdy_pkg.sv
package uart_rdy_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_FIFO = 2'd1,
        MODE_DMA  = 2'd2
    } rdy_mode_e;

    typedef enum logic {
        RX_OPEN    = 1'b0,
        RX_LATCHED = 1'b1
    } rxdma_state_e;

endpackage

// File: rtl/uart_rdy_fifo.sv
module uart_rdy_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             cap_one,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    limit;
    logic             do_push;
    logic             do_pop;

    assign limit   = cap_one ? CW'(1) : CW'(DEPTH);
    assign do_push = push && (count < limit) && !flush;
    assign do_pop  = pop && (count != '0) && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R8
    AST_FULL_PUSH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !cap_one && count == CW'(DEPTH) && push && !pop) |=> count == CW'(DEPTH)); // R8
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && count == '0 && pop && !push) |=> count == '0); // R8
    AST_HOLD_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_one && !flush) |-> count <= CW'(1)); // R2

endmodule

// File: rtl/uart_rdy_mode.sv
module uart_rdy_mode
    import uart_rdy_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fifo_en,
    input  logic      dma_mode,
    output rdy_mode_e mode,
    output logic      flush
);

    logic fen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fen_q <= 1'b0;
        end else begin
            fen_q <= fifo_en;
        end
    end

    assign flush = fifo_en ^ fen_q;

    always_comb begin
        unique case ({fifo_en, dma_mode})
            2'b10:   mode = MODE_FIFO;
            2'b11:   mode = MODE_DMA;
            default: mode = MODE_HOLD;
        endcase
    end

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && $stable(fifo_en)) |=> !flush); // R12

endmodule

// File: rtl/uart_rdy_rxdma.sv
module uart_rdy_rxdma
    import uart_rdy_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic [CW-1:0] rx_cnt,
    input  logic [CW-1:0] trig,
    input  logic         timeout,
    output rxdma_state_e state_nxt
);

    rxdma_state_e state;

    always_comb begin
        state_nxt = state;
        if (!active) begin
            state_nxt = RX_OPEN;
        end else begin
            unique case (state)
                RX_OPEN: begin
                    if (rx_cnt != '0 && (rx_cnt >= trig || timeout)) begin
                        state_nxt = RX_LATCHED;
                    end
                end
                RX_LATCHED: begin
                    if (rx_cnt == '0) begin
                        state_nxt = RX_OPEN;
                    end
                end
                default: state_nxt = RX_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_OPEN;
        end else begin
            state <= state_nxt;
        end
    end

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && state == RX_LATCHED && rx_cnt != '0) |=> state == RX_LATCHED); // R5
    AST_EMPTY_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_OPEN && rx_cnt == '0) |=> state == RX_OPEN); // R5
    AST_INACTIVE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> state == RX_OPEN); // R12

endmodule

// File: rtl/uart_rdy_irq.sv
module uart_rdy_irq
    import uart_rdy_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             dma_mode,
    input  logic [CW-1:0]    rx_trig,
    input  logic             rx_timeout,
    input  logic             irq_tx_en,
    input  logic             irq_rx_en,
    input  logic             rx_push,
    input  logic [WIDTH-1:0] rx_din,
    input  logic             rx_pop,
    output logic [WIDTH-1:0] rx_dout,
    input  logic             tx_push,
    input  logic [WIDTH-1:0] tx_din,
    input  logic             tx_pop,
    output logic [WIDTH-1:0] tx_dout,
    output logic [CW-1:0]    rx_count,
    output logic [CW-1:0]    tx_count,
    output logic             rxrdy_n,
    output logic             txrdy_n,
    output logic             irq
);

    rdy_mode_e    mode;
    logic         flush;
    logic         cap_one;
    rxdma_state_e rx_state_nxt;
    logic [CW-1:0] rx_eff;
    logic [CW-1:0] tx_eff;
    logic         rxrdy_n_d;
    logic         txrdy_n_d;
    logic         tx_cond;
    logic         rx_cond;

    uart_rdy_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .mode     (mode),
        .flush    (flush)
    );

    assign cap_one = (mode == MODE_HOLD);

    uart_rdy_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .cap_one (cap_one),
        .push    (rx_push),
        .din     (rx_din),
        .pop     (rx_pop),
        .dout    (rx_dout),
        .count   (rx_count)
    );

    uart_rdy_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .cap_one (cap_one),
        .push    (tx_push),
        .din     (tx_din),
        .pop     (tx_pop),
        .dout    (tx_dout),
        .count   (tx_count)
    );

    // A flush empties both sides at this edge, so decode as if already empty.
    assign rx_eff = flush ? '0 : rx_count;
    assign tx_eff = flush ? '0 : tx_count;

    uart_rdy_rxdma #(.CW(CW)) u_rxdma (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    ((mode == MODE_DMA) && !flush),
        .rx_cnt    (rx_eff),
        .trig      (rx_trig),
        .timeout   (rx_timeout),
        .state_nxt (rx_state_nxt)
    );

    always_comb begin
        tx_cond = (tx_eff == '0);
        unique case (mode)
            MODE_HOLD: begin
                rxrdy_n_d = (rx_eff == '0);
                txrdy_n_d = (tx_eff != '0);
                rx_cond   = (rx_eff != '0);
            end
            MODE_FIFO: begin
                rxrdy_n_d = (rx_eff == '0);
                txrdy_n_d = (tx_eff != '0);
                rx_cond   = (rx_eff != '0) && (rx_eff >= rx_trig);
            end
            MODE_DMA: begin
                rxrdy_n_d = (rx_state_nxt != RX_LATCHED);
                txrdy_n_d = (tx_eff == CW'(DEPTH));
                rx_cond   = (rx_eff != '0) && (rx_eff >= rx_trig);
            end
            default: begin
                rxrdy_n_d = 1'b1;
                txrdy_n_d = 1'b1;
                rx_cond   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxrdy_n <= 1'b1;
            txrdy_n <= 1'b1;
            irq     <= 1'b0;
        end else begin
            rxrdy_n <= rxrdy_n_d;
            txrdy_n <= txrdy_n_d;
            irq     <= (irq_tx_en && tx_cond) || (irq_rx_en && rx_cond);
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (rx_count == '0 && tx_count == '0 && rxrdy_n)); // R12
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_tx_en && !irq_rx_en) |=> !irq); // R11
    AST_TX_DMA_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DMA && !flush && tx_count == CW'(DEPTH)) |=> txrdy_n); // R7
    AST_RX_EMPTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rx_count == '0) |=> rxrdy_n); // R4

endmodule

// File: tb/uart_rdy_irq_tb.sv
`timescale 1ns/1ps
module uart_rdy_irq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0, dma_mode = 1'b0;
    logic [4:0] rx_trig = 5'd4;
    logic       rx_timeout = 1'b0, irq_tx_en = 1'b0, irq_rx_en = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_din = '0, tx_din = '0;
    logic [7:0] rx_dout, tx_dout;
    logic [4:0] rx_count, tx_count;
    logic       rxrdy_n, txrdy_n, irq;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_rdy_irq dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .rx_trig(rx_trig), .rx_timeout(rx_timeout), .irq_tx_en(irq_tx_en),
        .irq_rx_en(irq_rx_en), .rx_push(rx_push), .rx_din(rx_din), .rx_pop(rx_pop),
        .rx_dout(rx_dout), .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop),
        .tx_dout(tx_dout), .rx_count(rx_count), .tx_count(tx_count),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk); rx_din = b; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        @(negedge clk); tx_din = b; tx_push = 1'b1;
        @(negedge clk); tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] b);
        @(negedge clk); b = rx_dout; rx_pop = 1'b1;
        @(negedge clk); rx_pop = 1'b0;
    endtask

    task automatic pop_tx(output logic [7:0] b);
        @(negedge clk); b = tx_dout; tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pulse_timeout();
        @(negedge clk); rx_timeout = 1'b1;
        @(negedge clk); rx_timeout = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rxrdy_n", rxrdy_n, 1);
        chk("R1 txrdy_n", txrdy_n, 1);
        chk("R1 irq", irq, 0);
        chk("R1 rx_count", rx_count, 0);
        chk("R1 tx_count", tx_count, 0);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_hold();
        logic [7:0] b;
        settle();
        chk("R3 txrdy_n empty holding", txrdy_n, 0);
        chk("R2 rxrdy_n no data", rxrdy_n, 1);
        push_rx(8'h5A);
        chk("R13 rxrdy_n not yet changed", rxrdy_n, 1);
        settle();
        chk("R2 rxrdy_n byte held", rxrdy_n, 0);
        push_rx(8'hC3);
        settle();
        chk("R2 second push ignored", rx_count, 1);
        @(negedge clk); irq_rx_en = 1'b1;
        settle();
        chk("R10 rx irq byte held", irq, 1);
        @(negedge clk); irq_rx_en = 1'b0;
        settle();
        chk("R11 irq masked", irq, 0);
        @(negedge clk); irq_tx_en = 1'b1;
        settle();
        chk("R9 tx irq empty", irq, 1);
        push_tx(8'h11);
        settle();
        chk("R3 txrdy_n byte held", txrdy_n, 1);
        chk("R9 tx irq byte held", irq, 0);
        pop_tx(b);
        chk("R8 tx head byte", b, 8'h11);
        settle();
        chk("R3 txrdy_n empty again", txrdy_n, 0);
        @(negedge clk); irq_tx_en = 1'b0;
        pop_rx(b);
        chk("R2 held byte", b, 8'h5A);
        settle();
        chk("R2 rxrdy_n empty again", rxrdy_n, 1);
    endtask

    task automatic t_fifo();
        logic [7:0] b;
        @(negedge clk); fifo_en = 1'b1;
        settle(); settle();
        chk("R12 rx empty after enable", rx_count, 0);
        push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
        settle();
        chk("R4 rxrdy_n data present", rxrdy_n, 0);
        chk("R8 rx count 3", rx_count, 3);
        for (int i = 1; i <= 3; i++) begin
            pop_rx(b);
            chk("R8 rx order", b, 8'hA0 + i);
        end
        settle();
        chk("R4 rxrdy_n empty", rxrdy_n, 1);
        push_tx(8'h00);
        settle();
        chk("R6 txrdy_n one byte", txrdy_n, 1);
        for (int i = 1; i < 16; i++) push_tx(8'(i));
        push_tx(8'hFF);
        settle();
        chk("R8 push when full ignored", tx_count, 16);
        for (int i = 0; i < 16; i++) begin
            pop_tx(b);
            chk("R8 tx order", b, i);
        end
        pop_tx(b);
        settle();
        chk("R8 pop when empty ignored", tx_count, 0);
        chk("R6 txrdy_n empty", txrdy_n, 0);
        @(negedge clk); rx_trig = 5'd4; irq_rx_en = 1'b1;
        push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
        settle();
        chk("R10 rx irq below trigger", irq, 0);
        push_rx(8'h04);
        settle();
        chk("R10 rx irq at trigger", irq, 1);
        for (int i = 0; i < 4; i++) pop_rx(b);
        settle();
        chk("R10 rx irq drained", irq, 0);
        @(negedge clk); irq_rx_en = 1'b0;
    endtask

    task automatic t_dma();
        logic [7:0] b;
        @(negedge clk); dma_mode = 1'b1; rx_trig = 5'd4;
        settle();
        chk("R5 rxrdy_n idle", rxrdy_n, 1);
        chk("R7 txrdy_n room", txrdy_n, 0);
        push_rx(8'h10); push_rx(8'h11); push_rx(8'h12);
        settle();
        chk("R5 below trigger", rxrdy_n, 1);
        push_rx(8'h13);
        settle();
        chk("R5 trigger reached", rxrdy_n, 0);
        for (int i = 0; i < 3; i++) pop_rx(b);
        settle();
        chk("R5 hysteresis below trigger", rxrdy_n, 0);
        pop_rx(b);
        settle();
        chk("R5 released when empty", rxrdy_n, 1);
        push_rx(8'h20);
        settle();
        chk("R5 single byte no latch", rxrdy_n, 1);
        pulse_timeout();
        settle();
        chk("R5 timeout latch", rxrdy_n, 0);
        pop_rx(b);
        settle();
        chk("R5 timeout released", rxrdy_n, 1);
        pulse_timeout();
        settle();
        chk("R5 timeout on empty ignored", rxrdy_n, 1);
        for (int i = 0; i < 15; i++) push_tx(8'(i));
        settle();
        chk("R7 txrdy_n at 15", txrdy_n, 0);
        push_tx(8'h0F);
        settle();
        chk("R7 txrdy_n full", txrdy_n, 1);
        pop_tx(b);
        settle();
        chk("R7 txrdy_n one free", txrdy_n, 0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 5; i++) push_rx(8'(i));
        settle();
        chk("R5 latched before flush", rxrdy_n, 0);
        @(negedge clk); fifo_en = 1'b0;
        settle(); settle();
        chk("R12 rx flushed", rx_count, 0);
        chk("R12 tx flushed", tx_count, 0);
        chk("R12 rxrdy_n high", rxrdy_n, 1);
        chk("R3 txrdy_n empty after flush", txrdy_n, 0);
        push_rx(8'h77);
        @(negedge clk); fifo_en = 1'b1;
        settle(); settle();
        chk("R12 flush on enable", rx_count, 0);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_fifo();
        t_dma();
        t_flush();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule